// File: doc/BRIEF.md
# Labeled Memory Operation Ordering Unit

This block sits between one processor and its memory port. The processor hands over memory operations in program order. Each operation names a read or a write, an address, a two-bit consistency label and an ordering mode. The unit keeps up to eight operations in flight. It sends each one to memory as soon as the rules of a properly-labeled consistency model allow. Ordinary accesses can therefore overlap and pass one another, while competing accesses keep the orderings that make a labeled program behave sequentially consistent.

Memory answers each request with a completion that carries the slot tag of that request. Completions may come back in any order. Operations leave the unit from the oldest slot once they have completed, and each departure is shown for one cycle. With the strict mode the unit degrades to one operation at a time, in program order. That setting is the safe fallback for code whose labels cannot be trusted.

Top module: `mo_order_buffer`

## Requirements
- R1: After reset `enq_ready` is 1, while `iss_valid` and `ret_valid` are 0. Slots are handed out in rotation starting at slot 0, and the slot number is the tag seen on `iss_tag`, `cmp_tag` and `ret_tag`.
- R2: The unit holds at most 8 operations. `enq_ready` is 0 while 8 are held, and an operation offered while `enq_ready` is 0 is not taken.
- R3: Label encoding: 00 is ordinary, 01 is competing non-sync, 10 and 11 are competing sync. Ordinary operations to different addresses issue without waiting for each other to complete, so several can be in flight at once.
- R4: An operation never issues while an older operation to the same address has not completed.
- R5: An acquire is a competing read with sync effect. No younger operation issues before the acquire completes. The acquire itself does not wait for older ordinary operations.
- R6: A release is a competing write with sync effect. It issues only once every older operation has completed. Younger ordinary operations may issue before it.
- R7: A competing operation issues only after every older competing operation has completed, so at most one competing operation is in flight.
- R8: Mode encoding: 00 is level one, 01 is level two, 10 and 11 are strict. The mode is taken per operation at enqueue. In level one a non-sync label acts as sync. In level two a non-sync operation keeps only the competing order of R7, and ordinary operations pass it in both directions.
- R9: In strict mode every operation is treated as competing with sync effect. Operations then issue one at a time in program order, each after the previous one completes.
- R10: At most one operation issues per cycle, on `iss_valid` and `iss_ready`. The offered operation is always the oldest one that the rules allow. `iss_valid` is 0 when no operation is allowed.
- R11: `cmp_valid` marks a tagged operation complete, in any order. `ret_valid` pulses for the oldest held operation once its completion is registered. At most one operation retires per cycle, and retirement is in program order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Operation offered |
| enq_ready | output | 1 | A free slot exists |
| enq_write | input | 1 | 1 = write, 0 = read |
| enq_addr | input | AW | Operation address |
| enq_label | input | 2 | Consistency label (R3) |
| enq_mode | input | 2 | Ordering mode (R8) |
| iss_valid | output | 1 | Request to memory offered |
| iss_ready | input | 1 | Memory accepts the request |
| iss_tag | output | $clog2(DEPTH) | Slot of the offered request |
| iss_write | output | 1 | Direction of the offered request |
| iss_addr | output | AW | Address of the offered request |
| cmp_valid | input | 1 | Completion from memory |
| cmp_tag | input | $clog2(DEPTH) | Slot being completed |
| ret_valid | output | 1 | Oldest operation retires this cycle |
| ret_tag | output | $clog2(DEPTH) | Slot that retires |

## Verification
Ordinary-only streams with distinct addresses must show several requests in flight. The same streams confined to two or four addresses isolate the same-address stall. Mixed label streams in level one and level two tell the acquire, release and competing-order rules apart. For each such stream, a model built from the rules predicts the exact oldest allowed operation every cycle, with random memory latencies and a stalling memory port. All-sync and strict streams must never show more than one request outstanding. Short directed sequences pin down the exact cycles at which a release and an acquire unblock, the difference between a non-sync read in the two levels, back-pressure at eight entries, and in-order retirement after completions that arrive out of order.

// File: rtl/mo_pkg.sv
package mo_pkg;

    typedef enum logic [1:0] {
        LBL_ORD      = 2'd0,
        LBL_NSYNC    = 2'd1,
        LBL_SYNC     = 2'd2,
        LBL_SYNC_ALT = 2'd3
    } lbl_e;

    typedef enum logic [1:0] {
        MODE_L1         = 2'd0,
        MODE_L2         = 2'd1,
        MODE_STRICT     = 2'd2,
        MODE_STRICT_ALT = 2'd3
    } mode_e;

    // Ordering class resolved once, at enqueue
    typedef struct packed {
        logic comp;   // keeps order among competing operations
        logic acq;    // blocks every younger operation until done
        logic rel;    // waits for every older operation to be done
    } ord_cls_t;

    typedef struct packed {
        logic     valid;
        logic     issued;
        logic     done;
        logic     write;
        ord_cls_t cls;
    } slot_t;

    function automatic ord_cls_t classify(input logic write, input lbl_e lbl, input mode_e mode);
        ord_cls_t c;
        logic strict;
        logic sync;
        strict = mode[1];
        c.comp = strict | (lbl != LBL_ORD);
        sync   = strict | lbl[1] | ((lbl == LBL_NSYNC) && (mode == MODE_L1));
        c.acq  = c.comp & sync & ~write;
        c.rel  = c.comp & sync & write;
        return c;
    endfunction

endpackage

// File: rtl/mo_slot_table.sv
module mo_slot_table
    import mo_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       alloc_en,
    input  logic [IW-1:0]              alloc_idx,
    input  logic                       alloc_write,
    input  logic [AW-1:0]              alloc_addr,
    input  ord_cls_t                   alloc_cls,
    input  logic                       issue_en,
    input  logic [IW-1:0]              issue_idx,
    input  logic                       cmpl_en,
    input  logic [IW-1:0]              cmpl_idx,
    input  logic                       retire_en,
    input  logic [IW-1:0]              retire_idx,
    output slot_t [DEPTH-1:0]          slots,
    output logic  [DEPTH-1:0][AW-1:0]  addrs
);

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        logic hit_alloc, hit_issue, hit_cmpl, hit_ret;
        assign hit_alloc = alloc_en  && (alloc_idx  == IW'(s));
        assign hit_issue = issue_en  && (issue_idx  == IW'(s));
        assign hit_cmpl  = cmpl_en   && (cmpl_idx   == IW'(s));
        assign hit_ret   = retire_en && (retire_idx == IW'(s));

        always_ff @(posedge clk) begin
            if (rst) begin
                slots[s] <= '0;
                addrs[s] <= '0;
            end else if (hit_alloc) begin
                slots[s].valid  <= 1'b1;
                slots[s].issued <= 1'b0;
                slots[s].done   <= 1'b0;
                slots[s].write  <= alloc_write;
                slots[s].cls    <= alloc_cls;
                addrs[s]        <= alloc_addr;
            end else if (hit_ret) begin
                slots[s].valid  <= 1'b0;
                slots[s].issued <= 1'b0;
                slots[s].done   <= 1'b0;
            end else begin
                if (hit_issue && slots[s].valid)
                    slots[s].issued <= 1'b1;
                if (hit_cmpl && slots[s].valid && slots[s].issued)
                    slots[s].done <= 1'b1;
            end
        end

        AST_DONE_NEEDS_ISSUE: assert property (@(posedge clk) disable iff (rst)
            slots[s].done |-> (slots[s].issued && slots[s].valid)); // R11
    end

    AST_ALLOC_FREE: assert property (@(posedge clk) disable iff (rst)
        alloc_en |-> !slots[alloc_idx].valid); // R2

    AST_RETIRE_DONE: assert property (@(posedge clk) disable iff (rst)
        retire_en |-> slots[retire_idx].done); // R11

endmodule

// File: rtl/mo_hazard.sv
module mo_hazard
    import mo_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    localparam int IW   = $clog2(DEPTH)
) (
    input  slot_t [DEPTH-1:0]          slots,
    input  logic  [DEPTH-1:0][AW-1:0]  addrs,
    input  logic  [IW-1:0]             head,
    output logic  [DEPTH-1:0]          elig
);

    // One row of the older-than matrix per slot
    for (genvar i = 0; i < DEPTH; i++) begin : g_row
        logic [IW-1:0] rank_i;
        logic          blk_acq, blk_comp, blk_rel, blk_addr;

        assign rank_i = IW'(i) - head;

        always_comb begin
            blk_acq  = 1'b0;
            blk_comp = 1'b0;
            blk_rel  = 1'b0;
            blk_addr = 1'b0;
            for (int j = 0; j < DEPTH; j++) begin
                logic [IW-1:0] rank_j;
                rank_j = IW'(j) - head;
                if (slots[j].valid && !slots[j].done && (rank_j < rank_i)) begin
                    if (slots[j].cls.acq)                          blk_acq  = 1'b1;
                    if (slots[i].cls.comp && slots[j].cls.comp)    blk_comp = 1'b1;
                    if (slots[i].cls.rel)                          blk_rel  = 1'b1;
                    if (addrs[j] == addrs[i])                      blk_addr = 1'b1;
                end
            end
        end

        assign elig[i] = slots[i].valid && !slots[i].issued &&
                         !(blk_acq || blk_comp || blk_rel || blk_addr);
    end

endmodule

// File: rtl/mo_pick.sv
module mo_pick #(
    parameter int DEPTH = 8,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] elig,
    input  logic [IW-1:0]    head,
    output logic             found,
    output logic [IW-1:0]    idx
);

    // Scan from the head so the first hit is the oldest
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = 0; k < DEPTH; k++) begin
            logic [IW-1:0] cand;
            cand = head + IW'(k);
            if (!found && elig[cand]) begin
                found = 1'b1;
                idx   = cand;
            end
        end
    end

endmodule

// File: rtl/mo_order_buffer.sv
module mo_order_buffer
    import mo_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = IW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enq_valid,
    output logic          enq_ready,
    input  logic          enq_write,
    input  logic [AW-1:0] enq_addr,
    input  logic [1:0]    enq_label,
    input  logic [1:0]    enq_mode,
    output logic          iss_valid,
    input  logic          iss_ready,
    output logic [IW-1:0] iss_tag,
    output logic          iss_write,
    output logic [AW-1:0] iss_addr,
    input  logic          cmp_valid,
    input  logic [IW-1:0] cmp_tag,
    output logic          ret_valid,
    output logic [IW-1:0] ret_tag
);

    logic [IW-1:0]             head, tail;
    logic [CW-1:0]             count;
    slot_t [DEPTH-1:0]         slots;
    logic [DEPTH-1:0][AW-1:0]  addrs;
    logic [DEPTH-1:0]          elig;
    logic                      pick_found;
    logic [IW-1:0]             pick_idx;
    logic                      enq_fire, iss_fire;
    ord_cls_t                  new_cls;

    assign new_cls   = classify(enq_write, lbl_e'(enq_label), mode_e'(enq_mode));
    assign enq_ready = (count != CW'(DEPTH));
    assign enq_fire  = enq_valid && enq_ready;
    assign iss_valid = pick_found;
    assign iss_tag   = pick_idx;
    assign iss_write = slots[pick_idx].write;
    assign iss_addr  = addrs[pick_idx];
    assign iss_fire  = iss_valid && iss_ready;
    assign ret_valid = slots[head].valid && slots[head].done;
    assign ret_tag   = head;

    mo_slot_table #(.DEPTH(DEPTH), .AW(AW)) u_table (
        .clk        (clk),
        .rst        (rst),
        .alloc_en   (enq_fire),
        .alloc_idx  (tail),
        .alloc_write(enq_write),
        .alloc_addr (enq_addr),
        .alloc_cls  (new_cls),
        .issue_en   (iss_fire),
        .issue_idx  (pick_idx),
        .cmpl_en    (cmp_valid),
        .cmpl_idx   (cmp_tag),
        .retire_en  (ret_valid),
        .retire_idx (head),
        .slots      (slots),
        .addrs      (addrs)
    );

    mo_hazard #(.DEPTH(DEPTH), .AW(AW)) u_hazard (
        .slots(slots),
        .addrs(addrs),
        .head (head),
        .elig (elig)
    );

    mo_pick #(.DEPTH(DEPTH)) u_pick (
        .elig (elig),
        .head (head),
        .found(pick_found),
        .idx  (pick_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (enq_fire)  tail <= tail + IW'(1);
            if (ret_valid) head <= head + IW'(1);
            count <= count + CW'(enq_fire) - CW'(ret_valid);
        end
    end

    // Observation vectors for the checks below
    logic [DEPTH-1:0] vld_v, flight_v, comp_flight_v;
    logic             older_open, older_acq_open;
    logic [IW-1:0]    tag_rank;

    always_comb begin
        tag_rank       = pick_idx - head;
        older_open     = 1'b0;
        older_acq_open = 1'b0;
        for (int j = 0; j < DEPTH; j++) begin
            vld_v[j]         = slots[j].valid;
            flight_v[j]      = slots[j].valid && slots[j].issued && !slots[j].done;
            comp_flight_v[j] = flight_v[j] && slots[j].cls.comp;
            if (slots[j].valid && !slots[j].done && ((IW'(j) - head) < tag_rank)) begin
                older_open = 1'b1;
                if (slots[j].issued && slots[j].cls.acq) older_acq_open = 1'b1;
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH)); // R2

    AST_COUNT_MATCH: assert property (@(posedge clk) disable iff (rst)
        $countones(vld_v) == int'(count)); // R2

    AST_ONE_COMPETING: assert property (@(posedge clk) disable iff (rst)
        $countones(comp_flight_v) <= 1); // R7

    AST_RELEASE_DRAINED: assert property (@(posedge clk) disable iff (rst)
        (iss_fire && slots[pick_idx].cls.rel) |-> !older_open); // R6

    AST_ACQUIRE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        iss_fire |-> !older_acq_open); // R5

    AST_ISSUE_MARKED: assert property (@(posedge clk) disable iff (rst)
        iss_fire |=> slots[$past(pick_idx)].issued); // R10

endmodule

// File: tb/tb_mo_order_buffer.sv
module tb_mo_order_buffer;

    localparam int DEPTH = 8;
    localparam int AW    = 16;
    localparam int IW    = 3;
    localparam int MAXS  = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          enq_valid = 1'b0;
    logic          enq_ready;
    logic          enq_write = 1'b0;
    logic [AW-1:0] enq_addr = '0;
    logic [1:0]    enq_label = 2'd0;
    logic [1:0]    enq_mode = 2'd0;
    logic          iss_valid;
    logic          iss_ready = 1'b0;
    logic [IW-1:0] iss_tag;
    logic          iss_write;
    logic [AW-1:0] iss_addr;
    logic          cmp_valid = 1'b0;
    logic [IW-1:0] cmp_tag = '0;
    logic          ret_valid;
    logic [IW-1:0] ret_tag;

    always #5 clk = ~clk;

    mo_order_buffer #(.DEPTH(DEPTH), .AW(AW)) dut (
        .clk(clk), .rst(rst),
        .enq_valid(enq_valid), .enq_ready(enq_ready), .enq_write(enq_write),
        .enq_addr(enq_addr), .enq_label(enq_label), .enq_mode(enq_mode),
        .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_tag(iss_tag),
        .iss_write(iss_write), .iss_addr(iss_addr),
        .cmp_valid(cmp_valid), .cmp_tag(cmp_tag),
        .ret_valid(ret_valid), .ret_tag(ret_tag)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    initial begin
        #1500000;
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // Stimulus rows: mode, label mix, address spread, max latency, ready gaps,
    // op count, overlap expectation (0: peak 1, 1: peak above 1, 2: any), requirement
    typedef struct packed {
        logic [1:0]  mode;
        logic [1:0]  lsel;     // 0 ordinary, 1 mixed, 2 all sync
        logic [1:0]  amode;    // 0 distinct, 1 two addresses, 2 four addresses
        logic [3:0]  maxlat;
        logic        gap;
        logic [7:0]  nops;
        logic [1:0]  ovl;
        logic [3:0]  req;
        logic [15:0] seed;
    } row_t;

    localparam int NROWS = 8;
    localparam row_t ROWS [NROWS] = '{
        '{2'd0, 2'd0, 2'd0, 4'd8, 1'b0, 8'd16, 2'd1, 4'd3,  16'h1234}, // R3 overlap
        '{2'd0, 2'd0, 2'd1, 4'd5, 1'b0, 8'd20, 2'd2, 4'd4,  16'h2345}, // R4 same address
        '{2'd0, 2'd1, 2'd2, 4'd7, 1'b0, 8'd30, 2'd2, 4'd5,  16'h3456}, // R5 R6 level one mix
        '{2'd1, 2'd1, 2'd2, 4'd7, 1'b0, 8'd30, 2'd2, 4'd8,  16'h4567}, // R8 level two mix
        '{2'd2, 2'd1, 2'd2, 4'd6, 1'b0, 8'd20, 2'd0, 4'd9,  16'h5678}, // R9 strict
        '{2'd0, 2'd2, 2'd2, 4'd6, 1'b0, 8'd20, 2'd0, 4'd7,  16'h6789}, // R7 all competing
        '{2'd0, 2'd1, 2'd0, 4'd9, 1'b1, 8'd30, 2'd2, 4'd10, 16'h789a}, // R10 stalling port
        '{2'd1, 2'd1, 2'd1, 4'd4, 1'b1, 8'd30, 2'd2, 4'd11, 16'h89ab}  // R11 out-of-order done
    };

    // Reference model state, indexed by program-order sequence
    bit            m_write [MAXS];
    logic [AW-1:0] m_addr  [MAXS];
    bit            m_comp  [MAXS];
    bit            m_acq   [MAXS];
    bit            m_rel   [MAXS];
    logic [1:0]    m_lbl   [MAXS];
    bit            m_iss   [MAXS];
    bit            m_done  [MAXS];
    int            m_due   [MAXS];
    int            n_enq, n_ret;
    int unsigned   lfsr;

    function automatic int unsigned rnd();
        lfsr ^= lfsr << 13;
        lfsr ^= lfsr >> 17;
        lfsr ^= lfsr << 5;
        return lfsr;
    endfunction

    // Ordering class taken from the requirement text (R3, R5, R6, R8, R9)
    task automatic set_class(input int s, input logic [1:0] lbl, input logic [1:0] mode);
        bit strict, sync;
        strict    = mode[1];
        m_comp[s] = strict || (lbl != 2'd0);
        sync      = strict || lbl[1] || (lbl == 2'd1 && mode == 2'd0);
        m_acq[s]  = m_comp[s] && sync && !m_write[s];
        m_rel[s]  = m_comp[s] && sync && m_write[s];
    endtask

    function automatic bit m_elig(input int s);
        if (s >= n_enq || m_iss[s]) return 1'b0;
        for (int p = n_ret; p < s; p++) begin
            if (!m_done[p]) begin
                if (m_acq[p] || (m_comp[s] && m_comp[p]) || m_rel[s] || m_addr[p] == m_addr[s])
                    return 1'b0;
            end
        end
        return 1'b1;
    endfunction

    task automatic do_reset();
        enq_valid = 1'b0;
        iss_ready = 1'b0;
        cmp_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic put(input bit w, input int a, input logic [1:0] lbl, input logic [1:0] mode);
        enq_valid = 1'b1;
        enq_write = w;
        enq_addr  = AW'(a);
        enq_label = lbl;
        enq_mode  = mode;
        @(negedge clk);
        enq_valid = 1'b0;
    endtask

    task automatic expect_iss(input bit v, input int tag, input string req);
        chk(iss_valid == v, req, "iss_valid", int'(iss_valid), int'(v));
        if (v) chk(int'(iss_tag) == tag, req, "iss_tag", int'(iss_tag), tag);
    endtask

    task automatic run_row(input row_t r);
        string rq;
        int    cyc, peak, outst, csel;
        bit    rdy;
        rq = $sformatf("R%0d", r.req);
        do_reset();
        lfsr  = {16'h9e37, r.seed};
        n_enq = 0;
        n_ret = 0;
        peak  = 0;
        for (int s = 0; s < MAXS; s++) begin
            m_iss[s]  = 1'b0;
            m_done[s] = 1'b0;
            m_due[s]  = 0;
        end
        for (int s = 0; s < int'(r.nops); s++) begin
            int unsigned v;
            v = rnd();
            m_write[s] = v[0];
            case (r.lsel)
                2'd0:    m_lbl[s] = 2'd0;
                2'd2:    m_lbl[s] = {1'b1, v[5]};
                default: m_lbl[s] = (v[2:1] < 2'd2) ? 2'd0 : ((v[2:1] == 2'd2) ? 2'd1 : {1'b1, v[5]});
            endcase
            case (r.amode)
                2'd0:    m_addr[s] = AW'(s);
                2'd1:    m_addr[s] = AW'(v[9:8] & 2'd1);
                default: m_addr[s] = AW'(v[9:8]);
            endcase
            set_class(s, m_lbl[s], r.mode);
        end
        cyc = 0;
        while (n_ret < int'(r.nops) && cyc < 4000) begin
            int exp_s;
            bit exp_ret;
            // choose inputs for this cycle
            rdy  = r.gap ? rnd() % 3 != 0 : 1'b1;
            csel = -1;
            for (int s = n_ret; s < n_enq; s++)
                if (csel < 0 && m_iss[s] && !m_done[s] && m_due[s] <= cyc) csel = s;
            iss_ready = rdy;
            cmp_valid = (csel >= 0);
            cmp_tag   = (csel >= 0) ? IW'(csel % DEPTH) : '0;
            if (n_enq < int'(r.nops)) begin
                enq_valid = 1'b1;
                enq_write = m_write[n_enq];
                enq_addr  = m_addr[n_enq];
                enq_label = m_lbl[n_enq];
                enq_mode  = r.mode;
            end else begin
                enq_valid = 1'b0;
            end
            #1;
            // back-pressure (R2)
            chk(enq_ready == ((n_enq - n_ret) < DEPTH), "R2", "enq_ready", int'(enq_ready), int'((n_enq - n_ret) < DEPTH));
            // oldest allowed operation (R10 and the row's rule)
            exp_s = -1;
            for (int s = n_ret; s < n_enq; s++)
                if (exp_s < 0 && m_elig(s)) exp_s = s;
            chk(iss_valid == (exp_s >= 0), rq, "iss_valid", int'(iss_valid), int'(exp_s >= 0));
            if (iss_valid && exp_s >= 0) begin
                chk(int'(iss_tag) == exp_s % DEPTH, "R10", "iss_tag", int'(iss_tag), exp_s % DEPTH);
                chk(iss_addr == m_addr[exp_s] && iss_write == m_write[exp_s], rq, "iss_addr", int'(iss_addr), int'(m_addr[exp_s]));
                if (rdy) begin
                    m_iss[exp_s] = 1'b1;
                    m_due[exp_s] = cyc + 1 + int'(rnd() % r.maxlat);
                end
            end
            // in-order retirement (R11)
            exp_ret = (n_ret < n_enq) && m_done[n_ret];
            chk(ret_valid == exp_ret, "R11", "ret_valid", int'(ret_valid), int'(exp_ret));
            if (ret_valid && exp_ret) begin
                chk(int'(ret_tag) == n_ret % DEPTH, "R11", "ret_tag", int'(ret_tag), n_ret % DEPTH);
                n_ret++;
            end
            if (csel >= 0) m_done[csel] = 1'b1;
            if (enq_valid && enq_ready) n_enq++;
            outst = 0;
            for (int s = 0; s < n_enq; s++)
                if (m_iss[s] && !m_done[s]) outst++;
            if (outst > peak) peak = outst;
            @(negedge clk);
            cyc++;
        end
        enq_valid = 1'b0;
        cmp_valid = 1'b0;
        chk(n_ret == int'(r.nops), rq, "retired count", n_ret, int'(r.nops));
        if (r.ovl == 2'd1) chk(peak > 1, rq, "peak in flight above one", peak, 2);
        if (r.ovl == 2'd0) chk(peak == 1, rq, "peak in flight", peak, 1);
    endtask

    initial begin
        // R1: reset state
        do_reset();
        chk(enq_ready == 1'b1, "R1", "enq_ready", int'(enq_ready), 1);
        chk(iss_valid == 1'b0, "R1", "iss_valid", int'(iss_valid), 0);
        chk(ret_valid == 1'b0, "R1", "ret_valid", int'(ret_valid), 0);

        // R2: fill eight slots with the port stalled, ninth offer refused
        iss_ready = 1'b0;
        for (int k = 0; k < 9; k++) begin
            chk(enq_ready == (k < 8), "R2", "enq_ready while filling", int'(enq_ready), int'(k < 8));
            put(1'b0, 16 + k, 2'd0, 2'd0);
        end
        expect_iss(1'b1, 0, "R1");
        iss_ready = 1'b1;
        for (int k = 0; k < 8; k++) begin
            expect_iss(1'b1, k, "R10");
            @(negedge clk);
        end
        expect_iss(1'b0, 0, "R2");
        iss_ready = 1'b0;
        // R11: complete slot 7 first, then 0..6; retire must follow program order
        begin
            int nexp;
            nexp = 0;
            for (int c = 0; c < 20; c++) begin
                cmp_valid = (c < 8);
                cmp_tag   = (c == 0) ? IW'(7) : IW'(c - 1);
                if (c == 1) chk(ret_valid == 1'b0, "R11", "retire before head done", int'(ret_valid), 0);
                if (ret_valid) begin
                    chk(int'(ret_tag) == nexp, "R11", "ret_tag order", int'(ret_tag), nexp);
                    nexp++;
                end
                @(negedge clk);
            end
            cmp_valid = 1'b0;
            chk(nexp == 8, "R11", "retired count", nexp, 8);
        end
        expect_iss(1'b0, 0, "R2");
        chk(enq_ready == 1'b1, "R2", "enq_ready after drain", int'(enq_ready), 1);

        // R5 R6 R7: ordinary write, release, ordinary read, acquire, ordinary read
        do_reset();
        put(1'b1, 1, 2'd0, 2'd0);
        put(1'b1, 2, 2'd2, 2'd0);
        put(1'b0, 3, 2'd0, 2'd0);
        put(1'b0, 4, 2'd3, 2'd0);
        put(1'b0, 5, 2'd0, 2'd0);
        expect_iss(1'b1, 0, "R10");
        iss_ready = 1'b1;
        @(negedge clk);
        expect_iss(1'b1, 2, "R6");   // ordinary read passes the waiting release
        @(negedge clk);
        expect_iss(1'b0, 0, "R6");   // release still waits for slot 0
        cmp_valid = 1'b1; cmp_tag = 3'd0;
        @(negedge clk);
        cmp_valid = 1'b0;
        expect_iss(1'b1, 1, "R6");
        @(negedge clk);
        expect_iss(1'b0, 0, "R7");   // acquire waits for the competing release
        cmp_valid = 1'b1; cmp_tag = 3'd1;
        @(negedge clk);
        cmp_valid = 1'b0;
        expect_iss(1'b1, 3, "R5");   // acquire goes with slot 2 still open
        @(negedge clk);
        expect_iss(1'b0, 0, "R5");   // younger read held behind the acquire
        cmp_valid = 1'b1; cmp_tag = 3'd3;
        @(negedge clk);
        cmp_valid = 1'b0;
        expect_iss(1'b1, 4, "R5");
        @(negedge clk);
        iss_ready = 1'b0;

        // R8: non-sync read followed by an ordinary read, level two then level one
        do_reset();
        put(1'b0, 1, 2'd1, 2'd1);
        put(1'b0, 2, 2'd0, 2'd1);
        iss_ready = 1'b1;
        expect_iss(1'b1, 0, "R8");
        @(negedge clk);
        expect_iss(1'b1, 1, "R8");
        do_reset();
        put(1'b0, 1, 2'd1, 2'd0);
        put(1'b0, 2, 2'd0, 2'd0);
        iss_ready = 1'b1;
        expect_iss(1'b1, 0, "R8");
        @(negedge clk);
        expect_iss(1'b0, 0, "R8");

        // Randomized rows
        for (int r = 0; r < NROWS; r++) run_row(ROWS[r]);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule